// File: doc/BRIEF.md
# Address-Space-Tagged Translation Buffer

This block is a small fully associative translation buffer for a processor's memory pipeline. Every slot keeps a virtual page tag, a physical page number, a four-bit read mask, a four-bit write mask, a fault-on-read flag, a fault-on-write flag, a global flag and an address space number. A lookup presents a virtual address, the current address space number and an instruction-side flag. One cycle later the block returns hit or miss, the attributes of the matching slot and the physical address. Permission checks are left to the consumer.

New translations enter through an insert port. Each insert fills the slot named by a wrapping replacement pointer. Three invalidation commands exist: clear everything, drop every non-global slot, and drop the slots that match one page under the lookup rule. A 64-bit readback word shows the slot under the replacement pointer, and a readback strobe can step the pointer on. A three-deep list of recently hit slots is probed ahead of the main array. It is emptied by every insert and by every invalidation.

Top module: `asn_tlb`

## Requirements
- R1: A slot hits only if it is valid, its tag equals the lookup VPN (virtual address bits above the 13-bit page offset), and either its global flag is set or its stored address space number equals `lk_asn`.
- R2: Results are registered. `rs_valid`, `rs_hit` and the result fields appear on the clock edge after the cycle in which `lk_valid` is high. On a miss every result field and `rs_paddr` are zero. When several array slots match, the lowest index wins.
- R3: An insert writes the slot at the replacement pointer, marks it valid and tags it with the VPN of `ins_vaddr`, replacing whatever that slot held. The pointer then moves up by one and wraps from 15 back to 0.
- R4: `fl_all` invalidates and zeroes every slot and puts the replacement pointer back to 0.
- R5: `fl_proc` invalidates every slot whose global flag is clear and leaves global slots usable.
- R6: `fl_addr` invalidates every slot that would hit under the R1 rule for the VPN of `fl_vaddr` and the number `fl_asn`. Global slots with that tag are included.
- R7: `rs_paddr` is the physical page number above the 13-bit page offset of the lookup address. When `lk_ifetch` is high, offset bits 1:0 are returned as zero.
- R8: A three-entry list of recently hit slots is probed first, in order 0, 1, 2, and a hit there sets `rs_from_sc` and takes precedence over the array's lowest index. A hit found only in the array pushes that slot to position 0 and shifts the older positions down. Any insert or invalidation empties the list.
- R9: `rb_word` shows the slot at the replacement pointer, OR-combined as follows: the physical page number shifted left by 32, the read mask at bits 11:8, the write mask at bits 15:12, fault-on-read at bit 1, fault-on-write at bit 2, global at bit 4, and the address space number shifted left by 57. A cycle with `rb_adv` high steps the pointer by one with wrap. An insert in the same cycle steps it only once.
- R10: When an invalidation and an insert fall in the same cycle, the invalidation is applied first and the insert after it. The new slot therefore survives. With `fl_all`, the insert lands in slot 0 and the pointer ends at 1.
- R11: After reset every slot is invalid and zero, the pointer is 0, `rs_valid` and `rs_hit` are 0, and `rb_word` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lk_valid | input | 1 | Lookup request this cycle |
| lk_vaddr | input | 43 | Lookup virtual address |
| lk_asn | input | 7 | Current address space number |
| lk_ifetch | input | 1 | Instruction-side lookup, forces offset bits 1:0 to zero |
| ins_valid | input | 1 | Insert request |
| ins_vaddr | input | 43 | Virtual address whose VPN tags the new slot |
| ins_ppn | input | 27 | Physical page number of the new slot |
| ins_rmask | input | 4 | Read permission mask |
| ins_wmask | input | 4 | Write permission mask |
| ins_fault_rd | input | 1 | Fault-on-read flag |
| ins_fault_wr | input | 1 | Fault-on-write flag |
| ins_global | input | 1 | Global flag: match any address space |
| ins_asn | input | 7 | Address space number of the new slot |
| fl_all | input | 1 | Invalidate all slots and reset the pointer |
| fl_proc | input | 1 | Invalidate all non-global slots |
| fl_addr | input | 1 | Invalidate the slots matching one page |
| fl_vaddr | input | 43 | Page address for `fl_addr` |
| fl_asn | input | 7 | Address space number for `fl_addr` |
| rb_adv | input | 1 | Step the replacement pointer after readback |
| rb_word | output | 64 | Readback word of the slot at the pointer |
| rs_valid | output | 1 | A lookup result is present |
| rs_hit | output | 1 | The lookup hit |
| rs_from_sc | output | 1 | The hit came from the recent-hit list |
| rs_paddr | output | 40 | Physical address |
| rs_rmask | output | 4 | Read mask of the hit slot |
| rs_wmask | output | 4 | Write mask of the hit slot |
| rs_fault_rd | output | 1 | Fault-on-read of the hit slot |
| rs_fault_wr | output | 1 | Fault-on-write of the hit slot |
| rs_global | output | 1 | Global flag of the hit slot |
| rs_asn | output | 7 | Address space number of the hit slot |

## Verification
The functions that can meet in one cycle are an invalidation and an insert. The bench raises the process flush, the page flush and the full flush each in the same cycle as an insert. For the process and page flushes, the inserted translation is non-global or carries the flushed tag. Afterwards lookups must still hit the new translation while the older victims miss. For the full flush, the readback word must show an empty slot 1, and must show the new translation again after the pointer is stepped round to slot 0.

// File: rtl/tlb_pkg.sv
// Shared types of the translation buffer.
// Holds the permission and flag part of a slot; widths here are fixed by the
// readback word layout, address widths stay parameters of the modules.
package tlb_pkg;
    localparam int PERM_W = 4;

    typedef struct packed {
        logic [PERM_W-1:0] rmask;
        logic [PERM_W-1:0] wmask;
        logic              f_rd;
        logic              f_wr;
        logic              glob;
    } tlb_attr_t;
endpackage

// File: rtl/tlb_match.sv
// Parallel tag compare over all slots.
// Produces one match bit per slot: valid, tag equal, and global or same
// address space number. Purely combinational; used for lookup and page flush.
module tlb_match #(
    parameter int ENTRIES = 16,
    parameter int VPN_W   = 30,
    parameter int ASN_W   = 7
) (
    input  logic [ENTRIES-1:0] vld,
    input  logic [ENTRIES-1:0] glob,
    input  logic [VPN_W-1:0]   tag [ENTRIES],
    input  logic [ASN_W-1:0]   asn [ENTRIES],
    input  logic [VPN_W-1:0]   q_vpn,
    input  logic [ASN_W-1:0]   q_asn,
    output logic [ENTRIES-1:0] hit
);
    // one comparator per slot
    for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
        assign hit[i] = vld[i] && (tag[i] == q_vpn) && (glob[i] || asn[i] == q_asn);
    end
endmodule

// File: rtl/tlb_mru.sv
// Three-deep list of recently hit slot indices, probed ahead of the array.
// Assumes the caller clears it whenever slot contents change (insert/flush),
// so a stored index never points at a rewritten slot.
module tlb_mru #(
    parameter int ENTRIES = 16,
    parameter int DEPTH   = 3
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [ENTRIES-1:0]         match,
    input  logic                       probe,
    input  logic                       arr_hit,
    input  logic [$clog2(ENTRIES)-1:0] arr_idx,
    input  logic                       clear,
    output logic                       sc_hit,
    output logic [$clog2(ENTRIES)-1:0] sc_idx
);
    localparam int IDX_W = $clog2(ENTRIES);

    logic [DEPTH-1:0] pos_v;
    logic [IDX_W-1:0] pos_idx [DEPTH];
    logic [DEPTH-1:0] pos_hit;

    // a list position hits when it is filled and its slot matches now
    for (genvar k = 0; k < DEPTH; k++) begin : g_probe
        assign pos_hit[k] = pos_v[k] && match[pos_idx[k]];
    end

    // first hitting position wins, position 0 first
    always_comb begin
        sc_hit = |pos_hit;
        sc_idx = '0;
        for (int k = DEPTH - 1; k >= 0; k--) begin
            if (pos_hit[k]) sc_idx = pos_idx[k];
        end
    end

    // clear on content change, otherwise push array hits to the head
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos_v <= '0;
            for (int k = 0; k < DEPTH; k++) pos_idx[k] <= '0;
        end else if (clear) begin
            pos_v <= '0;
        end else if (probe && !sc_hit && arr_hit) begin
            pos_v      <= {pos_v[DEPTH-2:0], 1'b1};
            pos_idx[0] <= arr_idx;
            for (int k = 1; k < DEPTH; k++) pos_idx[k] <= pos_idx[k-1];
        end
    end

    AST_MRU_EMPTY_AFTER_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (pos_v == '0)); // R8
    AST_MRU_PUSH_HEAD: assert property (@(posedge clk) disable iff (!rst_n)
        (probe && !sc_hit && arr_hit && !clear) |=> (pos_v[0] && pos_idx[0] == $past(arr_idx))); // R8
endmodule

// File: rtl/asn_tlb.sv
// Fully associative translation buffer tagged by address space number.
// Holds the slots, the wrapping replacement pointer, the three invalidation
// commands, the registered lookup result and the readback word.
// Assumes ENTRIES is a power of two and the page number fits 27 readback bits.
module asn_tlb #(
    parameter int ENTRIES    = 16,
    parameter int PAGE_SHIFT = 13,
    parameter int VA_W       = 43,
    parameter int PA_W       = 40,
    parameter int ASN_W      = 7,
    parameter int SC_DEPTH   = 3
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       lk_valid,
    input  logic [VA_W-1:0]            lk_vaddr,
    input  logic [ASN_W-1:0]           lk_asn,
    input  logic                       lk_ifetch,
    input  logic                       ins_valid,
    input  logic [VA_W-1:0]            ins_vaddr,
    input  logic [PA_W-PAGE_SHIFT-1:0] ins_ppn,
    input  logic [3:0]                 ins_rmask,
    input  logic [3:0]                 ins_wmask,
    input  logic                       ins_fault_rd,
    input  logic                       ins_fault_wr,
    input  logic                       ins_global,
    input  logic [ASN_W-1:0]           ins_asn,
    input  logic                       fl_all,
    input  logic                       fl_proc,
    input  logic                       fl_addr,
    input  logic [VA_W-1:0]            fl_vaddr,
    input  logic [ASN_W-1:0]           fl_asn,
    input  logic                       rb_adv,
    output logic [63:0]                rb_word,
    output logic                       rs_valid,
    output logic                       rs_hit,
    output logic                       rs_from_sc,
    output logic [PA_W-1:0]            rs_paddr,
    output logic [3:0]                 rs_rmask,
    output logic [3:0]                 rs_wmask,
    output logic                       rs_fault_rd,
    output logic                       rs_fault_wr,
    output logic                       rs_global,
    output logic [ASN_W-1:0]           rs_asn
);
    import tlb_pkg::*;

    localparam int IDX_W  = $clog2(ENTRIES);
    localparam int VPN_W  = VA_W - PAGE_SHIFT;
    localparam int PPN_W  = PA_W - PAGE_SHIFT;
    localparam int RB_PPN = 32;
    localparam int RB_ASN = 57;

    logic [ENTRIES-1:0] e_vld;
    logic [VPN_W-1:0]   e_tag  [ENTRIES];
    logic [PPN_W-1:0]   e_ppn  [ENTRIES];
    tlb_attr_t          e_attr [ENTRIES];
    logic [ASN_W-1:0]   e_asn  [ENTRIES];
    logic [ENTRIES-1:0] e_glob;
    logic [IDX_W-1:0]   ptr;

    logic [ENTRIES-1:0] lk_match, fa_match, kill;
    logic               arr_hit, sc_hit, any_hit;
    logic [IDX_W-1:0]   arr_idx, sc_idx, sel;
    logic [IDX_W-1:0]   ins_slot, ptr_base, ptr_nxt;
    logic               sc_clear, rs_ifetch_q;
    logic [PAGE_SHIFT-1:0] off_eff;

    // gather the global flags as a vector for the comparators
    for (genvar i = 0; i < ENTRIES; i++) begin : g_glob
        assign e_glob[i] = e_attr[i].glob;
    end

    tlb_match #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .ASN_W(ASN_W)) lk_cmp_i (
        .vld(e_vld), .glob(e_glob), .tag(e_tag), .asn(e_asn),
        .q_vpn(lk_vaddr[VA_W-1:PAGE_SHIFT]), .q_asn(lk_asn), .hit(lk_match));

    tlb_match #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .ASN_W(ASN_W)) fa_cmp_i (
        .vld(e_vld), .glob(e_glob), .tag(e_tag), .asn(e_asn),
        .q_vpn(fl_vaddr[VA_W-1:PAGE_SHIFT]), .q_asn(fl_asn), .hit(fa_match));

    // lowest matching array index
    always_comb begin
        arr_hit = |lk_match;
        arr_idx = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (lk_match[i]) arr_idx = IDX_W'(i);
        end
    end

    assign sc_clear = ins_valid || fl_all || fl_proc || fl_addr;

    tlb_mru #(.ENTRIES(ENTRIES), .DEPTH(SC_DEPTH)) sc_i (
        .clk(clk), .rst_n(rst_n), .match(lk_match), .probe(lk_valid),
        .arr_hit(arr_hit), .arr_idx(arr_idx), .clear(sc_clear),
        .sc_hit(sc_hit), .sc_idx(sc_idx));

    // shortcut list takes precedence over the array
    assign any_hit = sc_hit || arr_hit;
    assign sel     = sc_hit ? sc_idx : arr_idx;

    // slots dropped by the process or page flush
    always_comb begin
        for (int i = 0; i < ENTRIES; i++) begin
            kill[i] = e_vld[i] && ((fl_proc && !e_glob[i]) || (fl_addr && fa_match[i]));
        end
    end

    // flush-all rewinds the pointer before the insert uses it
    always_comb begin
        ptr_base = fl_all ? '0 : ptr;
        ins_slot = ptr_base;
        ptr_nxt  = ptr_base;
        if (ins_valid || rb_adv) begin
            ptr_nxt = (ptr_base == IDX_W'(ENTRIES - 1)) ? '0 : ptr_base + 1'b1;
        end
    end

    // slot storage: flush first, insert over it
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            e_vld <= '0;
            ptr   <= '0;
            for (int i = 0; i < ENTRIES; i++) begin
                e_tag[i]  <= '0;
                e_ppn[i]  <= '0;
                e_attr[i] <= '0;
                e_asn[i]  <= '0;
            end
        end else begin
            for (int i = 0; i < ENTRIES; i++) begin
                if (ins_valid && IDX_W'(i) == ins_slot) begin
                    e_vld[i]  <= 1'b1;
                    e_tag[i]  <= ins_vaddr[VA_W-1:PAGE_SHIFT];
                    e_ppn[i]  <= ins_ppn;
                    e_attr[i] <= '{rmask: ins_rmask, wmask: ins_wmask, f_rd: ins_fault_rd,
                                   f_wr: ins_fault_wr, glob: ins_global};
                    e_asn[i]  <= ins_asn;
                end else if (fl_all) begin
                    e_vld[i]  <= 1'b0;
                    e_tag[i]  <= '0;
                    e_ppn[i]  <= '0;
                    e_attr[i] <= '0;
                    e_asn[i]  <= '0;
                end else if (kill[i]) begin
                    e_vld[i] <= 1'b0;
                end
            end
            ptr <= ptr_nxt;
        end
    end

    // page offset, word aligned for instruction-side lookups
    always_comb begin
        off_eff = lk_vaddr[PAGE_SHIFT-1:0];
        if (lk_ifetch) off_eff[1:0] = 2'b00;
    end

    // registered lookup result, zero on miss
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rs_valid <= 1'b0; rs_hit <= 1'b0; rs_from_sc <= 1'b0; rs_ifetch_q <= 1'b0;
            rs_paddr <= '0; rs_rmask <= '0; rs_wmask <= '0;
            rs_fault_rd <= 1'b0; rs_fault_wr <= 1'b0; rs_global <= 1'b0; rs_asn <= '0;
        end else begin
            rs_valid    <= lk_valid;
            rs_hit      <= lk_valid && any_hit;
            rs_from_sc  <= lk_valid && sc_hit;
            rs_ifetch_q <= lk_valid && lk_ifetch;
            if (lk_valid && any_hit) begin
                rs_paddr    <= {e_ppn[sel], off_eff};
                rs_rmask    <= e_attr[sel].rmask;
                rs_wmask    <= e_attr[sel].wmask;
                rs_fault_rd <= e_attr[sel].f_rd;
                rs_fault_wr <= e_attr[sel].f_wr;
                rs_global   <= e_attr[sel].glob;
                rs_asn      <= e_asn[sel];
            end else begin
                rs_paddr <= '0; rs_rmask <= '0; rs_wmask <= '0;
                rs_fault_rd <= 1'b0; rs_fault_wr <= 1'b0; rs_global <= 1'b0; rs_asn <= '0;
            end
        end
    end

    // readback word of the slot under the pointer
    always_comb begin
        rb_word        = (64'(e_ppn[ptr]) << RB_PPN) | (64'(e_asn[ptr]) << RB_ASN);
        rb_word[11:8]  = e_attr[ptr].rmask;
        rb_word[15:12] = e_attr[ptr].wmask;
        rb_word[1]     = e_attr[ptr].f_rd;
        rb_word[2]     = e_attr[ptr].f_wr;
        rb_word[4]     = e_attr[ptr].glob;
    end

    AST_HIT_NEEDS_LOOKUP: assert property (@(posedge clk) disable iff (!rst_n)
        rs_hit |-> rs_valid); // R1
    AST_MISS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rs_valid && !rs_hit) |-> (rs_paddr == '0 && rs_asn == '0)); // R2
    AST_PTR_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (ins_valid && !fl_all && ptr == IDX_W'(ENTRIES - 1)) |=> (ptr == '0)); // R3
    AST_FLUSH_ALL_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        (fl_all && !ins_valid) |=> (e_vld == '0 && ptr == '0)); // R4
    AST_GLOBAL_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (fl_proc && !fl_all && !fl_addr && !ins_valid) |=> (($past(e_vld & e_glob) & ~e_vld) == '0)); // R5
    AST_PAGE_GONE: assert property (@(posedge clk) disable iff (!rst_n)
        (fl_addr && !fl_all && !ins_valid) |=> ((e_vld & $past(fa_match)) == '0)); // R6
    AST_IFETCH_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
        (rs_ifetch_q && rs_hit) |-> (rs_paddr[1:0] == 2'b00)); // R7
    AST_INSERT_SURVIVES_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
        ins_valid |=> e_vld[$past(ins_slot)]); // R10
endmodule

// File: tb/asn_tlb_tb_top.sv
`timescale 1ns/1ps
module asn_tlb_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lk_valid = 0, lk_ifetch = 0;
    logic [42:0] lk_vaddr = '0;
    logic [6:0]  lk_asn = '0;
    logic        ins_valid = 0, ins_fault_rd = 0, ins_fault_wr = 0, ins_global = 0;
    logic [42:0] ins_vaddr = '0;
    logic [26:0] ins_ppn = '0;
    logic [3:0]  ins_rmask = '0, ins_wmask = '0;
    logic [6:0]  ins_asn = '0;
    logic        fl_all = 0, fl_proc = 0, fl_addr = 0, rb_adv = 0;
    logic [42:0] fl_vaddr = '0;
    logic [6:0]  fl_asn = '0;
    logic [63:0] rb_word;
    logic        rs_valid, rs_hit, rs_from_sc, rs_fault_rd, rs_fault_wr, rs_global;
    logic [39:0] rs_paddr;
    logic [3:0]  rs_rmask, rs_wmask;
    logic [6:0]  rs_asn;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    always #10 clk = ~clk;

    asn_tlb dut_i (
        .clk(clk), .rst_n(rst_n),
        .lk_valid(lk_valid), .lk_vaddr(lk_vaddr), .lk_asn(lk_asn), .lk_ifetch(lk_ifetch),
        .ins_valid(ins_valid), .ins_vaddr(ins_vaddr), .ins_ppn(ins_ppn),
        .ins_rmask(ins_rmask), .ins_wmask(ins_wmask), .ins_fault_rd(ins_fault_rd),
        .ins_fault_wr(ins_fault_wr), .ins_global(ins_global), .ins_asn(ins_asn),
        .fl_all(fl_all), .fl_proc(fl_proc), .fl_addr(fl_addr),
        .fl_vaddr(fl_vaddr), .fl_asn(fl_asn), .rb_adv(rb_adv), .rb_word(rb_word),
        .rs_valid(rs_valid), .rs_hit(rs_hit), .rs_from_sc(rs_from_sc), .rs_paddr(rs_paddr),
        .rs_rmask(rs_rmask), .rs_wmask(rs_wmask), .rs_fault_rd(rs_fault_rd),
        .rs_fault_wr(rs_fault_wr), .rs_global(rs_global), .rs_asn(rs_asn));

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // readback layout as given in R9
    function automatic logic [63:0] rbw(input logic [26:0] ppn, input logic [3:0] rm,
                                        input logic [3:0] wm, input logic fr, input logic fw,
                                        input logic g, input logic [6:0] asn);
        logic [63:0] w;
        w = (64'(ppn) << 32) | (64'(asn) << 57);
        w[11:8] = rm; w[15:12] = wm; w[1] = fr; w[2] = fw; w[4] = g;
        return w;
    endfunction

    // end one cycle: wait for the next falling edge, drop all strobes
    task automatic step();
        @(negedge clk);
        ins_valid = 0; fl_all = 0; fl_proc = 0; fl_addr = 0; lk_valid = 0; rb_adv = 0;
    endtask

    task automatic set_ins(input logic [29:0] vpn, input logic [26:0] ppn, input logic [3:0] rm,
                           input logic [3:0] wm, input logic fr, input logic fw,
                           input logic g, input logic [6:0] asn);
        ins_valid = 1; ins_vaddr = {vpn, 13'h0}; ins_ppn = ppn; ins_rmask = rm;
        ins_wmask = wm; ins_fault_rd = fr; ins_fault_wr = fw; ins_global = g; ins_asn = asn;
    endtask

    task automatic ins(input logic [29:0] vpn, input logic [26:0] ppn, input logic g,
                       input logic [6:0] asn);
        set_ins(vpn, ppn, 4'h5, 4'h3, 1'b0, 1'b0, g, asn);
        step();
    endtask

    task automatic look(input logic [29:0] vpn, input logic [12:0] off,
                        input logic [6:0] asn, input logic ifetch);
        lk_valid = 1; lk_vaddr = {vpn, off}; lk_asn = asn; lk_ifetch = ifetch;
        step();
    endtask

    task automatic flush_all();
        fl_all = 1;
        step();
    endtask

    task automatic advance(input int n);
        for (int k = 0; k < n; k++) begin
            rb_adv = 1;
            step();
        end
    endtask

    task automatic t_reset();
        chk("R11 rs_valid", 64'(rs_valid), 0);
        chk("R11 rs_hit", 64'(rs_hit), 0);
        chk("R11 rb_word", rb_word, 0);
    endtask

    task automatic t_match();
        flush_all();
        ins(30'h100, 27'h55, 0, 7'd3);
        ins(30'h200, 27'h66, 1, 7'd3);
        look(30'h100, 13'h0, 7'd3, 0);
        chk("R1 asn match hit", 64'(rs_hit), 1);
        chk("R1 asn match ppn", 64'(rs_paddr), {27'h55, 13'h0});
        look(30'h100, 13'h0, 7'd4, 0);
        chk("R1 asn mismatch miss", 64'(rs_hit), 0);
        chk("R2 miss valid", 64'(rs_valid), 1);
        chk("R2 miss paddr zero", 64'(rs_paddr), 0);
        look(30'h200, 13'h0, 7'd9, 0);
        chk("R1 global hit", {rs_hit, rs_global}, 2'b11);
        look(30'h300, 13'h0, 7'd3, 0);
        chk("R1 tag miss", 64'(rs_hit), 0);
    endtask

    task automatic t_paddr();
        look(30'h100, 13'h1a7, 7'd3, 0);
        chk("R7 data paddr", 64'(rs_paddr), {27'h55, 13'h1a7});
        chk("R7 masks", {rs_rmask, rs_wmask}, 8'h53);
        look(30'h100, 13'h1a7, 7'd3, 1);
        chk("R7 ifetch paddr", 64'(rs_paddr), {27'h55, 13'h1a4});
    endtask

    task automatic t_wrap();
        flush_all();
        for (int i = 0; i < 16; i++) begin
            set_ins(30'h1000 + 30'(i), 27'h2000 + 27'(i), 4'(i), ~4'(i), i[0], i[1], 0, 7'(i));
            step();
        end
        chk("R9 readback slot0", rb_word, rbw(27'h2000, 4'h0, 4'hf, 0, 0, 0, 7'd0));
        advance(1);
        chk("R9 readback advance", rb_word, rbw(27'h2001, 4'h1, 4'he, 1, 0, 0, 7'd1));
        ins(30'h3000, 27'h77, 0, 7'd1);
        look(30'h1001, 13'h0, 7'd1, 0);
        chk("R3 replaced slot misses", 64'(rs_hit), 0);
        look(30'h3000, 13'h0, 7'd1, 0);
        chk("R3 new slot hits", 64'(rs_paddr), {27'h77, 13'h0});
        look(30'h1000, 13'h0, 7'd0, 0);
        chk("R3 slot0 kept", 64'(rs_paddr), {27'h2000, 13'h0});
        chk("R3 pointer at 2", rb_word, rbw(27'h2002, 4'h2, 4'hd, 0, 1, 0, 7'd2));
    endtask

    task automatic t_flush_all();
        flush_all();
        look(30'h1000, 13'h0, 7'd0, 0);
        chk("R4 flushed miss", 64'(rs_hit), 0);
        chk("R4 readback zero", rb_word, 0);
        set_ins(30'h44, 27'h99, 4'ha, 4'h6, 1, 1, 1, 7'h55);
        step();
        advance(15);
        chk("R4 pointer was 0", rb_word, rbw(27'h99, 4'ha, 4'h6, 1, 1, 1, 7'h55));
    endtask

    task automatic t_flush_proc();
        flush_all();
        ins(30'h10, 27'h1, 0, 7'd1);
        ins(30'h20, 27'h2, 1, 7'd1);
        ins(30'h30, 27'h3, 0, 7'd2);
        fl_proc = 1;
        step();
        look(30'h10, 13'h0, 7'd1, 0);
        chk("R5 non-global dropped", 64'(rs_hit), 0);
        look(30'h20, 13'h0, 7'd5, 0);
        chk("R5 global kept", 64'(rs_paddr), {27'h2, 13'h0});
        look(30'h30, 13'h0, 7'd2, 0);
        chk("R5 other asn dropped", 64'(rs_hit), 0);
    endtask

    task automatic t_flush_addr();
        flush_all();
        ins(30'h40, 27'h4, 0, 7'd1);
        ins(30'h40, 27'h5, 0, 7'd2);
        ins(30'h50, 27'h6, 0, 7'd1);
        ins(30'h60, 27'h7, 1, 7'd7);
        fl_addr = 1; fl_vaddr = {30'h40, 13'h0}; fl_asn = 7'd1;
        step();
        look(30'h40, 13'h0, 7'd1, 0);
        chk("R6 page dropped", 64'(rs_hit), 0);
        look(30'h40, 13'h0, 7'd2, 0);
        chk("R6 other asn kept", 64'(rs_paddr), {27'h5, 13'h0});
        look(30'h50, 13'h0, 7'd1, 0);
        chk("R6 other page kept", 64'(rs_paddr), {27'h6, 13'h0});
        fl_addr = 1; fl_vaddr = {30'h60, 13'h0}; fl_asn = 7'd1;
        step();
        look(30'h60, 13'h0, 7'd7, 0);
        chk("R6 global page dropped", 64'(rs_hit), 0);
    endtask

    task automatic t_shortcut();
        flush_all();
        ins(30'h80, 27'ha0, 0, 7'd1);
        ins(30'h80, 27'ha1, 1, 7'd0);
        look(30'h80, 13'h0, 7'd1, 0);
        chk("R2 lowest index", {rs_from_sc, 27'(rs_paddr >> 13)}, {1'b0, 27'ha0});
        look(30'h80, 13'h0, 7'd2, 0);
        chk("R8 array hit slot1", {rs_from_sc, 27'(rs_paddr >> 13)}, {1'b0, 27'ha1});
        look(30'h80, 13'h0, 7'd1, 0);
        chk("R8 shortcut first", {rs_from_sc, 27'(rs_paddr >> 13)}, {1'b1, 27'ha1});
        ins(30'h90, 27'ha2, 0, 7'd1);
        look(30'h80, 13'h0, 7'd1, 0);
        chk("R8 cleared by insert", {rs_from_sc, 27'(rs_paddr >> 13)}, {1'b0, 27'ha0});
    endtask

    task automatic t_same_cycle();
        flush_all();
        ins(30'h70, 27'hb0, 0, 7'd1);
        fl_proc = 1;
        set_ins(30'h78, 27'hb1, 4'h5, 4'h3, 0, 0, 0, 7'd1);
        step();
        look(30'h70, 13'h0, 7'd1, 0);
        chk("R10 old dropped", 64'(rs_hit), 0);
        look(30'h78, 13'h0, 7'd1, 0);
        chk("R10 insert survives proc", 64'(rs_paddr), {27'hb1, 13'h0});
        fl_all = 1;
        set_ins(30'h88, 27'hb2, 4'h1, 4'h2, 0, 1, 0, 7'd1);
        step();
        look(30'h88, 13'h0, 7'd1, 0);
        chk("R10 insert survives all", 64'(rs_paddr), {27'hb2, 13'h0});
        look(30'h78, 13'h0, 7'd1, 0);
        chk("R10 all flushed", 64'(rs_hit), 0);
        chk("R10 pointer at 1", rb_word, 0);
        fl_addr = 1; fl_vaddr = {30'h88, 13'h0}; fl_asn = 7'd1;
        set_ins(30'h88, 27'hb3, 4'h5, 4'h3, 0, 0, 0, 7'd1);
        step();
        look(30'h88, 13'h0, 7'd1, 0);
        chk("R10 insert survives page", 64'(rs_paddr), {27'hb3, 13'h0});
        advance(14);
        chk("R10 slot0 from flush-all", rb_word, rbw(27'hb2, 4'h1, 4'h2, 0, 1, 0, 7'd1));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_match();
        t_paddr();
        t_wrap();
        t_flush_all();
        t_flush_proc();
        t_flush_addr();
        t_shortcut();
        t_same_cycle();
        done = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule